// File: doc/BRIEF.md
# Output Buffer Trim Calibration Sequencer

This block steps an output buffer's offset trim code until an analog comparator reports that the offset has been corrected. A single-cycle start request switches the converter channel off and loads trim code zero. The block then holds each code for a settling window of 64 microseconds and reads the comparator's calibration flag at the end of that window. It stops at the first code for which the flag is set, and it leaves that code on the trim output.

The settling window is given as a number of clock cycles, worked out at elaboration from the clock frequency in kHz and the settle time in microseconds. A parameter sets how many synchronizer flops the comparator flag passes through. If the flag stays clear all the way to the largest code, the sweep stops on that code and raises an error indication. Once calibration has run, the channel enable stays low. Turning the channel back on is left to the logic that owns the enable.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset, trim_o is 0, chan_en_o is 1, and busy_o, done_o and err_o are 0.
- R2: An accepted start drives chan_en_o to 0. chan_en_o then stays 0 during the sweep and after it, until the next reset.
- R3: An accepted start loads trim code 0. Each later step raises the code by exactly one.
- R4: Each code is held for exactly S = CLK_FREQ_KHZ*SETTLE_US/1000 cycles. The flag is read at the edge that closes the window, as it stood SYNC_STAGES cycles earlier.
- R5: The sweep ends at the first code whose window closes with the flag read as 1. trim_o keeps that code after the end, with err_o at 0.
- R6: If the flag is still 0 when the window of code 2^TRIM_W-1 closes, the sweep ends on that code and err_o goes to 1. err_o stays 1 until the next accepted start clears it.
- R7: busy_o is 1 from the cycle after an accepted start until the sweep ends. done_o is 1 for exactly one cycle, the first cycle in which busy_o is 0 again.
- R8: A start request that arrives while busy_o is 1 has no effect on the trim sequence or on when the sweep ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| cal_flag_i | input | 1 | Comparator calibration flag, may be asynchronous |
| trim_o | output | TRIM_W | Offset trim code applied to the buffer |
| chan_en_o | output | 1 | Converter channel enable |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Flag never set up to the largest code |

## Verification
The start request is sampled at edge E0. Counted from E0, busy_o rises in cycle 0 and code c is on trim_o from cycle c*S. When the sweep stops on code c, done_o is seen in cycle (c+1)*S. The bench drives inputs and samples outputs on the falling edge. Each run keeps a cycle index counted from E0, checks the trim value expected for that index in every cycle of the sweep, and checks completion and the error flag in exactly cycle (c+1)*S. A comparator model in the bench sets the flag once the trim code reaches a chosen target, and the expected final code, error flag and completion cycle are all computed from that target.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

   typedef enum logic [0:0] {
      CAL_IDLE  = 1'b0,
      CAL_SWEEP = 1'b1
   } cal_state_e;

   function automatic int unsigned settle_cycles(input int unsigned freq_khz,
                                                 input int unsigned settle_us);
      return (freq_khz * settle_us) / 1000;
   endfunction

endpackage

// File: rtl/trim_cal_sync.sv
module trim_cal_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_sync_pins;
         assign unused_sync_pins = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/trim_cal_timer.sv
module trim_cal_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);

   localparam int unsigned TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [TW-1:0] RELOAD = TW'(CYCLES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= RELOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/trim_cal_code.sv
module trim_cal_code #(
   parameter int unsigned TRIM_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              inc_i,
   output logic [TRIM_W-1:0] code_o,
   output logic              at_max_o
);

   localparam logic [TRIM_W-1:0] CODE_MAX = {TRIM_W{1'b1}};

   logic [TRIM_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (clear_i) begin
         code_q <= '0;
      end else if (inc_i) begin
         code_q <= code_q + 1'b1;
      end
   end

   assign code_o   = code_q;
   assign at_max_o = (code_q == CODE_MAX);

endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
   import trim_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic flag_i,
   input  logic expire_i,
   input  logic at_max_i,
   output logic clear_o,
   output logic inc_o,
   output logic load_o,
   output logic chan_en_o,
   output logic busy_o,
   output logic done_o,
   output logic err_o
);

   cal_state_e state_q;
   logic       win_end;
   logic       finish;

   assign win_end = (state_q == CAL_SWEEP) && expire_i;
   assign finish  = win_end && (flag_i || at_max_i);
   assign clear_o = (state_q == CAL_IDLE) && start_i;
   assign inc_o   = win_end && !flag_i && !at_max_i;
   assign load_o  = clear_o || inc_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CAL_IDLE;
         chan_en_o <= 1'b1;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (clear_o) begin
            state_q   <= CAL_SWEEP;
            chan_en_o <= 1'b0;
            busy_o    <= 1'b1;
            err_o     <= 1'b0;
         end else if (finish) begin
            state_q <= CAL_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            err_o   <= !flag_i;
         end
      end
   end

endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq #(
   parameter int unsigned TRIM_W       = 5,
   parameter int unsigned CLK_FREQ_KHZ = 250000,
   parameter int unsigned SETTLE_US    = 64,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cal_flag_i,
   output logic [TRIM_W-1:0] trim_o,
   output logic              chan_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int unsigned SETTLE_CYC = trim_cal_pkg::settle_cycles(CLK_FREQ_KHZ, SETTLE_US);

   generate
      if (TRIM_W < 1 || TRIM_W > 16) begin : g_bad_width
         $error("trim_cal_seq: TRIM_W out of range");
      end
      if (SETTLE_CYC <= SYNC_STAGES) begin : g_bad_settle
         $error("trim_cal_seq: settle window must exceed synchronizer depth");
      end
   endgenerate

   logic flag_s;
   logic expire;
   logic at_max;
   logic clear;
   logic inc;
   logic load;

   trim_cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cal_flag_i),
      .q_o   (flag_s)
   );

   trim_cal_timer #(.CYCLES(SETTLE_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .expire_o (expire)
   );

   trim_cal_code #(.TRIM_W(TRIM_W)) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear),
      .inc_i    (inc),
      .code_o   (trim_o),
      .at_max_o (at_max)
   );

   trim_cal_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .flag_i    (flag_s),
      .expire_i  (expire),
      .at_max_i  (at_max),
      .clear_o   (clear),
      .inc_o     (inc),
      .load_o    (load),
      .chan_en_o (chan_en_o),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .err_o     (err_o)
   );

endmodule

// File: rtl/trim_cal_seq_chk.sv
module trim_cal_seq_chk #(
   parameter int unsigned TRIM_W       = 5,
   parameter int unsigned CLK_FREQ_KHZ = 250000,
   parameter int unsigned SETTLE_US    = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TRIM_W-1:0] trim_o,
   input logic              chan_en_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o
);

   localparam int unsigned S = trim_cal_pkg::settle_cycles(CLK_FREQ_KHZ, SETTLE_US);
   localparam logic [TRIM_W-1:0] CODE_MAX = {TRIM_W{1'b1}};

   int unsigned win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 0;
      end else if (!busy_o) begin
         win_q <= 0;
      end else begin
         win_q <= (win_q == S - 1) ? 0 : win_q + 1;
      end
   end

   assert_en_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !chan_en_o);
   assert_en_stays_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en_o |=> !chan_en_o);
   assert_first_code_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (trim_o == '0));
   assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$stable(trim_o)) |-> ((trim_o - $past(trim_o)) == TRIM_W'(1)));
   assert_step_on_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$stable(trim_o)) |-> (win_q == 0));
   assert_end_on_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(win_q) == S - 1));
   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> $stable(trim_o));
   assert_err_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (trim_o == CODE_MAX));
   assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

bind trim_cal_seq trim_cal_seq_chk #(
   .TRIM_W       (TRIM_W),
   .CLK_FREQ_KHZ (CLK_FREQ_KHZ),
   .SETTLE_US    (SETTLE_US)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trim_o    (trim_o),
   .chan_en_o (chan_en_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/trim_cal_seq_tb.sv
`timescale 1ns/1ps
module trim_cal_seq_tb;

   localparam int unsigned TRIM_W   = 5;
   localparam int unsigned FREQ_KHZ = 250;
   localparam int unsigned SET_US   = 64;
   localparam int unsigned SYNC     = 2;
   localparam int          S        = (FREQ_KHZ * SET_US) / 1000;
   localparam int          CMAX     = (1 << TRIM_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              cal_flag_i;
   logic [TRIM_W-1:0] trim_o;
   logic              chan_en_o, busy_o, done_o, err_o;
   int                target = 1000;
   int                n_chk = 0;
   int                n_fail = 0;
   int                cyc = 0;

   always #2 clk = ~clk;

   assign cal_flag_i = (int'(trim_o) >= target);

   trim_cal_seq #(
      .TRIM_W(TRIM_W), .CLK_FREQ_KHZ(FREQ_KHZ), .SETTLE_US(SET_US), .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_flag_i(cal_flag_i),
      .trim_o(trim_o), .chan_en_o(chan_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic int exp_code(input int t);
      return (t > CMAX) ? CMAX : t;
   endfunction

   function automatic bit exp_err(input int t);
      return (t > CMAX);
   endfunction

   function automatic int exp_done_cycle(input int t);
      return (exp_code(t) + 1) * S;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   // One calibration run; poke_at >= 0 sends an extra start at that cycle index (R8).
   task automatic run_cal(input int t, input int poke_at, input string tag);
      int  k;
      bit  traj_ok;
      int  bad_trim;
      int  bad_k;
      @(negedge clk);
      target  = t;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      traj_ok = 1'b1;
      bad_trim = 0;
      bad_k = 0;
      chk(busy_o == 1'b1 && err_o == 1'b0, {"R7 busy set, err cleared R6 ", tag}, {busy_o, err_o}, 2);
      chk(chan_en_o == 1'b0, {"R2 channel off at start ", tag}, chan_en_o, 0);
      chk(trim_o == '0, {"R3 first code ", tag}, trim_o, 0);
      while (!done_o && k < 40 * S) begin
         if (trim_o != TRIM_W'(k / S) || !busy_o || chan_en_o) begin
            if (traj_ok) begin
               bad_trim = trim_o;
               bad_k = k;
            end
            traj_ok = 1'b0;
         end
         start_i = (poke_at >= 0 && k == poke_at);
         @(negedge clk);
         k++;
      end
      start_i = 1'b0;
      chk(traj_ok, {"R3 R4 trim trajectory ", tag}, bad_trim, bad_k / S);
      chk(k == exp_done_cycle(t), {"R4 R5 R8 completion cycle ", tag}, k, exp_done_cycle(t));
      chk(done_o && !busy_o, {"R7 done with busy low ", tag}, {done_o, busy_o}, 2);
      chk(int'(trim_o) == exp_code(t), {"R5 final code ", tag}, trim_o, exp_code(t));
      chk(err_o == exp_err(t), {"R6 error flag ", tag}, err_o, exp_err(t));
      @(negedge clk);
      chk(!done_o, {"R7 done one cycle ", tag}, done_o, 0);
      chk(int'(trim_o) == exp_code(t) && err_o == exp_err(t) && !chan_en_o,
          {"R2 R5 R6 held after done ", tag}, trim_o, exp_code(t));
   endtask

   initial begin
      void'($urandom(32'd20917));
      repeat (3) @(negedge clk);
      chk(trim_o == '0, "R1 reset trim", trim_o, 0);
      chk(chan_en_o == 1'b1, "R1 reset enable", chan_en_o, 1);
      chk(!busy_o && !done_o && !err_o, "R1 reset flags", {busy_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(chan_en_o == 1'b1 && !busy_o, "R1 idle after reset", {chan_en_o, busy_o}, 2);

      run_cal(0, -1, "flag already set");
      run_cal(5, -1, "target 5");
      run_cal(CMAX, -1, "target max");
      run_cal(CMAX + 1, -1, "never set");
      run_cal(3, -1, "after error");
      run_cal(7, S + 3, "start while busy");
      run_cal(9, 1, "start right after begin");
      run_cal(200, 4 * S, "far target with poke");

      for (int i = 0; i < 24; i++) begin
         int t;
         int p;
         t = int'($urandom % 40);
         p = ($urandom % 3 == 0) ? int'($urandom % (exp_done_cycle(t) - 1)) : -1;
         run_cal(t, p, $sformatf("random %0d", i));
      end

      finish_run();
   end

endmodule